// File: doc/BRIEF.md
# Sixteen-bit single-cycle load/store core

The core executes one 16-bit instruction per clock from an external instruction store. It holds eight 16-bit general registers, a program counter and a four-flag status word (negative, zero, carry, overflow). Each cycle it presents the program counter on the fetch port and decodes the returned word. It then does one of four things: an arithmetic or logic operation, a load from data memory, a store to data memory, or a conditional jump.

Both memories are assumed to answer combinationally within the cycle. A load writes the returned word into its register at the closing clock edge. A store drives its address, data and write strobe for the whole cycle in which it is the current instruction. The same adder computes ALU results and memory addresses, so loads and stores use the operation field to choose between base plus offset and base minus offset.

Top module: `mini16_core`

## Requirements
- R1: Instruction bits 15:14 choose the class: 00 ALU, 01 load, 10 store, 11 branch; exactly one class is active per instruction.
- R2: An ALU instruction writes register bits 13:11 with the result of register bits 5:3 combined with the second operand. Bits 8:7 choose the operation: 00 add, 01 subtract (first minus second), 10 AND, 11 OR. The word 0011010010011010 yields R6 = R3 - R2.
- R3: When bit 6 is 1, bits 2:0 are zero-extended and used as the second operand; when it is 0, bits 2:0 name a register.
- R4: An ALU instruction with bit 10 set writes the flags. N is result bit 15 and Z marks a zero result. Add sets C to the carry out; subtract sets C to 1 when no borrow occurs. V marks a signed overflow. AND and OR clear C and V. With bit 10 clear, the flags keep their value.
- R5: A load writes register bits 13:11 with the data word at the address formed from register bits 5:3 plus (bit 7 = 0) or minus (bit 7 = 1) the second operand. Loads and stores never change the flags, whatever bit 10 holds.
- R6: A store drives the write strobe high for its one cycle. It drives the address formed as for a load, and the contents of register bits 13:11 as write data.
- R7: A branch tests condition bits 13:11 against the flags: 000 always, 001 Z, 010 not Z, 011 N≠V, 100 Z or N≠V, 101 not Z and N=V, 110 N=V.
- R8: Condition code 111 never branches.
- R9: A taken branch loads the program counter with bits 10:0 zero-extended; every other instruction adds one.
- R10: A low reset at a clock edge clears the program counter, all eight registers and the flags.
- R11: Bit 9 has no effect on ALU, load or store instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 16 | Program counter, word address of the current instruction |
| imem_data | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 16 | Data memory word address |
| dmem_wdata | output | 16 | Data memory write data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 16 | Data memory read data at dmem_addr |

## Verification
A corrupted register shows on the data port at the first store that reads it, either as its data or through the computed address. The bench therefore ends each stretch of computation with stores whose address and data it predicts. A wrong flag stays hidden until the next conditional branch. It then shows on imem_addr one cycle later, either as a skipped store or as an unexpected one at a decoy address. Each conditional branch in the program sits right after the flag-setting instruction it depends on, so any divergence appears within two cycles.

// File: rtl/mini16_pkg.sv
// mini16_pkg: shared widths, field encodings and types of the 16-bit core.
// Assumes the fixed 16-bit instruction layout; widths derive from it.
package mini16_pkg;
    localparam int DW     = 16;   // data and instruction width
    localparam int NREG   = 8;    // general registers
    localparam int RA_W   = $clog2(NREG);
    localparam int TGT_W  = 11;   // branch target width
    localparam int PC_W   = 16;   // program counter width
    localparam int IMM_W  = 3;    // short constant width

    // instruction classes, bits 15:14
    localparam logic [1:0] CLS_ALU = 2'b00;
    localparam logic [1:0] CLS_LD  = 2'b01;
    localparam logic [1:0] CLS_ST  = 2'b10;
    localparam logic [1:0] CLS_BR  = 2'b11;

    // operations, bits 8:7
    localparam logic [1:0] OP_ADD = 2'b00;
    localparam logic [1:0] OP_SUB = 2'b01;
    localparam logic [1:0] OP_AND = 2'b10;
    localparam logic [1:0] OP_OR  = 2'b11;

    // branch conditions, bits 13:11
    localparam logic [2:0] CC_AL = 3'd0;
    localparam logic [2:0] CC_EQ = 3'd1;
    localparam logic [2:0] CC_NE = 3'd2;
    localparam logic [2:0] CC_LT = 3'd3;
    localparam logic [2:0] CC_LE = 3'd4;
    localparam logic [2:0] CC_GT = 3'd5;
    localparam logic [2:0] CC_GE = 3'd6;
    localparam logic [2:0] CC_NV = 3'd7;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [1:0]       cls;
        logic [RA_W-1:0]  rd;
        logic             upd;
        logic [1:0]       op;
        logic             imm;
        logic [RA_W-1:0]  rs1;
        logic [RA_W-1:0]  rs2;
        logic [2:0]       cc;
        logic [TGT_W-1:0] tgt;
    } dec_t;
endpackage

// File: rtl/m16_decode.sv
// m16_decode: splits an instruction word into fields and class strobes.
// Purely combinational; assumes the fixed 16-bit layout of mini16_pkg.
// Bit 9 is consumed only as part of the branch target.
module m16_decode
    import mini16_pkg::*;
(
    input  logic [DW-1:0] instr,
    output dec_t          dec,
    output logic          is_alu,
    output logic          is_ld,
    output logic          is_st,
    output logic          is_br
);
    // field extraction
    always_comb begin
        dec.cls = instr[15:14];
        dec.rd  = instr[13:11];
        dec.upd = instr[10];
        dec.op  = instr[8:7];
        dec.imm = instr[6];
        dec.rs1 = instr[5:3];
        dec.rs2 = instr[2:0];
        dec.cc  = instr[13:11];
        dec.tgt = instr[TGT_W-1:0];
    end

    // class strobes
    always_comb begin
        is_alu = (dec.cls == CLS_ALU);
        is_ld  = (dec.cls == CLS_LD);
        is_st  = (dec.cls == CLS_ST);
        is_br  = (dec.cls == CLS_BR);
    end
endmodule

// File: rtl/m16_regbank.sv
// m16_regbank: general register file, three combinational read ports and one
// write port. Synchronous active-low reset clears every register.
module m16_regbank #(
    parameter int W  = 16,
    parameter int N  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    logic [W-1:0] rf [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // one register: clear on reset, load on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                rf[g] <= '0;
            else if (we && (waddr == AW'(g)))
                rf[g] <= wdata;
        end

        AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (waddr == AW'(g))) |=> (rf[g] == $past(wdata))); // R5
        AST_RESET_CLEARS: assert property (@(posedge clk)
            (rst_n === 1'b0) |=> (rf[g] == '0)); // R10
    end

    // read ports
    always_comb begin
        rd1 = rf[ra1];
        rd2 = rf[ra2];
        rd3 = rf[ra3];
    end
endmodule

// File: rtl/m16_alu.sv
// m16_alu: add, subtract, AND, OR with flag generation.
// Subtract computes a - b; carry is 1 when no borrow occurs.
// Logic operations report C and V as zero.
module m16_alu
    import mini16_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] y,
    output flags_t       f
);
    logic [W:0] sum;

    // result and flag computation
    always_comb begin
        sum = '0;
        y   = '0;
        f   = '0;
        case (op)
            OP_ADD: begin
                sum = {1'b0, a} + {1'b0, b};
                y   = sum[W-1:0];
                f.c = sum[W];
                f.v = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            end
            OP_SUB: begin
                sum = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
                y   = sum[W-1:0];
                f.c = sum[W];
                f.v = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            end
            OP_AND: y = a & b;
            default: y = a | b;
        endcase
        f.n = y[W-1];
        f.z = (y == '0);
    end
endmodule

// File: rtl/m16_branch.sv
// m16_branch: resolves a branch condition against the stored flags.
// Relational codes are signed comparisons; code 7 never branches.
module m16_branch
    import mini16_pkg::*;
(
    input  logic       en,
    input  logic [2:0] cc,
    input  flags_t     f,
    output logic       take
);
    logic lt;

    // condition evaluation
    always_comb begin
        lt = f.n ^ f.v;
        case (cc)
            CC_AL:   take = en;
            CC_EQ:   take = en && f.z;
            CC_NE:   take = en && !f.z;
            CC_LT:   take = en && lt;
            CC_LE:   take = en && (f.z || lt);
            CC_GT:   take = en && !f.z && !lt;
            CC_GE:   take = en && !lt;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/mini16_core.sv
// mini16_core: single-cycle 16-bit load/store core.
// Assumes instruction and data memories answer combinationally within the
// cycle. Loads write back at the closing edge; stores strobe for one cycle.
module mini16_core
    import mini16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] imem_addr,
    input  logic [DW-1:0]   imem_data,
    output logic [DW-1:0]   dmem_addr,
    output logic [DW-1:0]   dmem_wdata,
    output logic            dmem_we,
    input  logic [DW-1:0]   dmem_rdata
);
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] pc_next;
    flags_t          psr;
    flags_t          alu_f;
    dec_t            dec;
    logic            is_alu, is_ld, is_st, is_br;
    logic [DW-1:0]   ra_val, rb_val, rd_val;
    logic [DW-1:0]   opnd_b, alu_y, wb_data;
    logic [1:0]      alu_op;
    logic            wb_en, flag_we, take;

    m16_decode u_dec (
        .instr  (imem_data),
        .dec    (dec),
        .is_alu (is_alu),
        .is_ld  (is_ld),
        .is_st  (is_st),
        .is_br  (is_br)
    );

    m16_regbank #(.W(DW), .N(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_en),
        .waddr (dec.rd),
        .wdata (wb_data),
        .ra1   (dec.rs1),
        .ra2   (dec.rs2),
        .ra3   (dec.rd),
        .rd1   (ra_val),
        .rd2   (rb_val),
        .rd3   (rd_val)
    );

    // second operand and operation select; memory classes only add or subtract
    always_comb begin
        opnd_b = dec.imm ? {{(DW-IMM_W){1'b0}}, dec.rs2} : rb_val;
        alu_op = is_alu ? dec.op : {1'b0, dec.op[0]};
    end

    m16_alu #(.W(DW)) u_alu (
        .a  (ra_val),
        .b  (opnd_b),
        .op (alu_op),
        .y  (alu_y),
        .f  (alu_f)
    );

    m16_branch u_br (
        .en   (is_br),
        .cc   (dec.cc),
        .f    (psr),
        .take (take)
    );

    // write-back, flag enable and data port drive
    always_comb begin
        wb_en      = is_alu || is_ld;
        wb_data    = is_ld ? dmem_rdata : alu_y;
        flag_we    = is_alu && dec.upd;
        dmem_addr  = alu_y;
        dmem_wdata = rd_val;
        dmem_we    = is_st;
        pc_next    = take ? {{(PC_W-TGT_W){1'b0}}, dec.tgt} : pc + PC_W'(1);
        imem_addr  = pc;
    end

    // program counter
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    // status flags
    always_ff @(posedge clk) begin
        if (!rst_n)       psr <= '0;
        else if (flag_we) psr <= alu_f;
    end

    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_alu, is_ld, is_st, is_br})); // R1
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_alu && dec.upd) |=> $stable(psr)); // R4
    AST_MEM_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ld || is_st) |=> $stable(psr)); // R5
    AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (is_alu && dec.upd && dec.op[1]) |=> (!psr.c && !psr.v)); // R4
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (pc == $past(pc) + PC_W'(1))); // R9
    AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pc == {{(PC_W-TGT_W){1'b0}}, $past(dec.tgt)})); // R9
    AST_NV_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && dec.cc == CC_NV) |-> !take); // R8
    AST_RESET_PC: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (pc == '0 && psr == '0)); // R10
endmodule

// File: tb/sim_mini16_core.sv
// sim_mini16_core: scoreboard bench. A driver task queues the predicted
// stores; a monitor pops and compares each store the core performs.
module sim_mini16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [15:0] imem [64];
    logic [15:0] dmem [16];

    logic [15:0] q_addr [$];
    logic [15:0] q_data [$];
    string       q_tag  [$];

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mini16_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[3:0]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[3:0]] <= dmem_wdata;
        cycles <= cycles + 1;
    end

    function automatic logic [15:0] f_alu(input logic [1:0] op, input logic p,
        input logic i, input logic [2:0] d, input logic [2:0] s1, input logic [2:0] s2);
        return {2'b00, d, p, 1'b0, op, i, s1, s2};
    endfunction
    function automatic logic [15:0] f_ld(input logic [1:0] op, input logic p,
        input logic i, input logic [2:0] d, input logic [2:0] s1, input logic [2:0] s2);
        return {2'b01, d, p, 1'b0, op, i, s1, s2};
    endfunction
    function automatic logic [15:0] f_st(input logic [1:0] op, input logic i,
        input logic [2:0] d, input logic [2:0] s1, input logic [2:0] s2);
        return {2'b10, d, 1'b0, 1'b0, op, i, s1, s2};
    endfunction
    function automatic logic [15:0] f_br(input logic [2:0] cc, input logic [10:0] t);
        return {2'b11, cc, t};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: queue one predicted store
    task automatic expect_store(input logic [15:0] a, input logic [15:0] d, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    // monitor: compare every store against the head of the queue
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dmem_we === 1'b1 && !done) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R6 unexpected store", {dmem_addr, dmem_wdata}, 32'h0);
            end else begin
                logic [15:0] ea, ed;
                string t;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                t  = q_tag.pop_front();
                check({dmem_addr, dmem_wdata} == {ea, ed}, t,
                      {dmem_addr, dmem_wdata}, {ea, ed});
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 32'(cycles), 32'd5000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 64; k++) imem[k] = 16'h0000;
        for (int k = 0; k < 16; k++) dmem[k] = 16'h0000;
        imem[0]  = f_st(2'b00, 1'b1, 3'd7, 3'd0, 3'd0);       // regs cleared
        imem[1]  = f_br(3'd1, 11'd40);                        // BEQ, Z=0 after reset
        imem[2]  = f_alu(2'b00, 1'b1, 1'b1, 3'd1, 3'd0, 3'd5); // R1=5
        imem[3]  = f_alu(2'b00, 1'b1, 1'b1, 3'd2, 3'd0, 3'd3); // R2=3
        imem[4]  = f_alu(2'b01, 1'b1, 1'b0, 3'd3, 3'd1, 3'd2); // R3=R1-R2=2
        imem[5]  = f_st(2'b00, 1'b1, 3'd3, 3'd0, 3'd0);
        imem[6]  = 16'b0011010010011010;                      // R6=R3-R2, N=1
        imem[7]  = f_st(2'b00, 1'b1, 3'd6, 3'd0, 3'd1);
        imem[8]  = f_br(3'd3, 11'd11);                        // BLT taken
        imem[9]  = f_st(2'b00, 1'b1, 3'd1, 3'd0, 3'd7);       // decoy
        imem[10] = f_st(2'b00, 1'b1, 3'd1, 3'd0, 3'd7);       // decoy
        imem[11] = f_br(3'd6, 11'd14);                        // BGE not taken
        imem[12] = f_st(2'b00, 1'b1, 3'd2, 3'd0, 3'd2);
        imem[13] = f_alu(2'b10, 1'b0, 1'b0, 3'd4, 3'd1, 3'd2); // R4=1, no flags
        imem[14] = f_br(3'd3, 11'd16);                        // BLT still taken
        imem[15] = f_st(2'b00, 1'b1, 3'd1, 3'd0, 3'd7);       // decoy
        imem[16] = f_alu(2'b11, 1'b1, 1'b0, 3'd5, 3'd1, 3'd2); // R5=7, flags 0
        imem[17] = f_st(2'b01, 1'b0, 3'd4, 3'd1, 3'd2);       // [R1-R2]
        imem[18] = f_st(2'b00, 1'b1, 3'd5, 3'd1, 3'd3);       // [R1+3]
        imem[19] = f_ld(2'b00, 1'b1, 1'b0, 3'd7, 3'd1, 3'd2); // R7=[8], P set
        imem[20] = f_st(2'b00, 1'b1, 3'd7, 3'd0, 3'd4);
        imem[21] = f_alu(2'b01, 1'b0, 1'b1, 3'd4, 3'd2, 3'd3); // R4=0, no flags
        imem[22] = f_br(3'd1, 11'd25);                        // BEQ not taken
        imem[23] = f_st(2'b00, 1'b1, 3'd4, 3'd0, 3'd5);
        imem[24] = f_alu(2'b01, 1'b1, 1'b1, 3'd4, 3'd2, 3'd3); // Z=1
        imem[25] = f_br(3'd1, 11'd27);                        // BEQ taken
        imem[26] = f_st(2'b00, 1'b1, 3'd1, 3'd0, 3'd7);       // decoy
        imem[27] = f_br(3'd4, 11'd29);                        // BLE taken
        imem[28] = f_st(2'b00, 1'b1, 3'd1, 3'd0, 3'd7);       // decoy
        imem[29] = f_br(3'd5, 11'd31);                        // BGT not taken
        imem[30] = f_st(2'b00, 1'b1, 3'd2, 3'd0, 3'd6);
        imem[31] = f_br(3'd7, 11'd33);                        // code 7 never
        imem[32] = f_st(2'b00, 1'b1, 3'd1, 3'd0, 3'd6);
        imem[33] = f_br(3'd2, 11'd35);                        // BNE not taken
        imem[34] = f_st(2'b00, 1'b1, 3'd3, 3'd0, 3'd7);
        imem[35] = f_alu(2'b00, 1'b0, 1'b1, 3'd4, 3'd1, 3'd2) | 16'h0200; // bit 9 set
        imem[36] = f_st(2'b00, 1'b1, 3'd4, 3'd0, 3'd3);
        imem[37] = f_br(3'd0, 11'd37);                        // branch always, self

        expect_store(16'd0, 16'h0000, "R10 registers cleared by reset");
        expect_store(16'd0, 16'h0002, "R2 subtract register operands");
        expect_store(16'd1, 16'hFFFF, "R2 worked example R6=R3-R2");
        expect_store(16'd2, 16'h0003, "R7 greater-or-equal not taken on N!=V");
        expect_store(16'd2, 16'h0001, "R6 store address base minus register");
        expect_store(16'd8, 16'h0007, "R3 OR result, constant offset");
        expect_store(16'd4, 16'h0007, "R5 load from computed address");
        expect_store(16'd5, 16'h0000, "R4 flags held with P clear, load kept flags");
        expect_store(16'd6, 16'h0003, "R7 greater-than not taken on Z");
        expect_store(16'd6, 16'h0005, "R8 code 111 falls through");
        expect_store(16'd7, 16'h0002, "R7 not-equal not taken on Z");
        expect_store(16'd3, 16'h0007, "R11 reserved bit ignored");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 16'd0, "R10 program counter at reset", 32'(imem_addr), 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        repeat (50) @(negedge clk);
        check(imem_addr == 16'd37, "R9 final program counter", 32'(imem_addr), 32'd37);
        check(q_addr.size() == 0, "R9 all predicted stores seen", 32'(q_addr.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule